// File: doc/BRIEF.md
# Row Prefix Sum Engine

This block turns one row of a square detection window into its running sums. A row holds 24 unsigned 8-bit pixels. The block returns 24 sums of 18 bits each, and sum x equals the total of pixels 0 through x. The result feeds the newest line of an integral-image window, so the block produces each completed line as a single unit and never shows a partial result.

The work is split into groups of eight pixels. In each clock cycle one group passes through an adder network together with the running total carried from the group to its left, so a full row needs three cycles. The first two groups wait in a staging buffer. When the last group finishes, all 24 sums are loaded into the output register at once and a one-cycle valid pulse is raised. A new row can be taken on the same edge that finishes the current one, so rows can stream at one per three cycles.

Row length, group width, pixel width, sum width and the adder network (a ripple chain or a logarithmic prefix tree) are all parameters. Elaboration-time checks reject combinations that would not fit.

Top module: `row_prefix_engine`

## Requirements
- R1: Output entry x (bits [x*18 +: 18] of `line_data`) equals the sum of input pixels 0..x, where pixel x is bits [x*8 +: 8] of `row_data`. Index 0 is the leftmost pixel.
- R2: If `row_valid` is high at a clock edge while the block is idle, that row is accepted. `line_valid` is then high for exactly one cycle: the cycle that follows the third clock edge after the accepting edge. `line_data` carries that row's result during this cycle.
- R3: A row offered at the edge that completes the current row is accepted at that edge. Rows can therefore be accepted every three cycles, and `line_valid` pulses are then exactly three cycles apart.
- R4: A row offered at any other edge while a row is in progress is ignored. It produces no extra `line_valid` pulse and does not alter the result of the row in progress.
- R5: `line_data` changes only in a cycle in which `line_valid` is high. Between pulses it holds the last completed line.
- R6: Sums do not wrap. A row of all 255 gives entry x = 255*(x+1), so the last entry is 6120.
- R7: While reset (`rst_n` low) is applied and afterwards until the first completed row, `line_valid` is 0 and `line_data` is all zeros.
- R8: Each row starts from a zero running total. A row accepted back-to-back after another row gets the same result as the same row accepted alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| row_valid | input | 1 | Offers `row_data` at this edge |
| row_data | input | 192 | 24 packed 8-bit pixels, pixel 0 in the low bits |
| line_valid | output | 1 | One-cycle pulse: `line_data` holds a fresh line |
| line_data | output | 432 | 24 packed 18-bit running sums, entry 0 in the low bits |

## Verification
A corrupted running total between groups would show up as wrong entries in the upper two thirds of the line. These errors appear in the same `line_valid` cycle and grow with the entry index. A stale carry from the previous row would shift every entry of the next row by a constant, which back-to-back rows make visible on their second pulse. A sequencer that loses track of the group index would either mistime the pulse or emit extra pulses. Either way, the error is visible within four cycles of the accepting edge. An output register written too early would change `line_data` between pulses, which the bench sees one cycle after the ignored offer or the group write.

// File: rtl/rpe_pkg.sv
package rpe_pkg;

   // Choice of adder network inside one pixel group
   typedef enum logic {
      ADD_RIPPLE  = 1'b0,   // linear chain, GROUP-1 adders deep
      ADD_LOGTREE = 1'b1    // prefix tree, log2(GROUP) adders deep
   } adder_style_e;

   // Smallest sum width that holds a full row of maximal pixels
   function automatic int unsigned min_sum_bits(input int unsigned row_len,
                                                input int unsigned pix_w);
      return $clog2(row_len * ((1 << pix_w) - 1) + 1);
   endfunction

   // Width of a counter that indexes n items (at least one bit)
   function automatic int unsigned idx_bits(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/rpe_group_adder.sv
// Running sums over one pixel group plus an incoming carry.
module rpe_group_adder #(
   parameter int unsigned PIX_W = 8,
   parameter int unsigned GROUP = 8,
   parameter int unsigned SUM_W = 18,
   parameter rpe_pkg::adder_style_e STYLE = rpe_pkg::ADD_LOGTREE
) (
   input  logic [GROUP*PIX_W-1:0] grp_pix,
   input  logic [SUM_W-1:0]       carry_in,
   output logic [GROUP*SUM_W-1:0] grp_sums
);

   localparam int unsigned LEVELS = (GROUP > 1) ? $clog2(GROUP) : 0;

   // zero-extended pixels
   logic [SUM_W-1:0] pix_ext [GROUP];

   for (genvar i = 0; i < GROUP; i++) begin : g_ext
      assign pix_ext[i] = SUM_W'(grp_pix[i*PIX_W +: PIX_W]);
   end

   if (STYLE == rpe_pkg::ADD_RIPPLE) begin : g_ripple
      logic [SUM_W-1:0] run [GROUP];
      for (genvar i = 0; i < GROUP; i++) begin : g_chain
         if (i == 0) begin : g_head
            assign run[i] = carry_in + pix_ext[i];
         end else begin : g_body
            assign run[i] = run[i-1] + pix_ext[i];
         end
         assign grp_sums[i*SUM_W +: SUM_W] = run[i];
      end
   end else begin : g_logtree
      logic [SUM_W-1:0] node [LEVELS+1][GROUP];
      for (genvar i = 0; i < GROUP; i++) begin : g_leaf
         if (i == 0) begin : g_head
            assign node[0][i] = carry_in + pix_ext[i];
         end else begin : g_body
            assign node[0][i] = pix_ext[i];
         end
      end
      for (genvar k = 0; k < LEVELS; k++) begin : g_level
         for (genvar i = 0; i < GROUP; i++) begin : g_col
            if (i >= (1 << k)) begin : g_add
               assign node[k+1][i] = node[k][i] + node[k][i-(1<<k)];
            end else begin : g_pass
               assign node[k+1][i] = node[k][i];
            end
         end
      end
      for (genvar i = 0; i < GROUP; i++) begin : g_out
         assign grp_sums[i*SUM_W +: SUM_W] = node[LEVELS][i];
      end
   end

endmodule

// File: rtl/rpe_sequencer.sv
// Steps through the groups of an accepted row.
module rpe_sequencer #(
   parameter int unsigned NUM_GROUPS = 3,
   localparam int unsigned GW = rpe_pkg::idx_bits(NUM_GROUPS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          row_valid,
   output logic          accept,
   output logic          busy,
   output logic [GW-1:0] grp,
   output logic          last
);

   logic          busy_q;
   logic [GW-1:0] grp_q;

   assign busy   = busy_q;
   assign grp    = grp_q;
   assign last   = busy_q && (grp_q == GW'(NUM_GROUPS - 1));
   assign accept = row_valid && (!busy_q || last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         grp_q  <= '0;
      end else if (accept) begin
         busy_q <= 1'b1;
         grp_q  <= '0;
      end else if (last) begin
         busy_q <= 1'b0;
         grp_q  <= '0;
      end else if (busy_q) begin
         grp_q  <= grp_q + GW'(1);
      end
   end

endmodule

// File: rtl/rpe_line_buffer.sv
// Collects group results and publishes the whole line at once.
module rpe_line_buffer #(
   parameter int unsigned ROW_LEN = 24,
   parameter int unsigned GROUP   = 8,
   parameter int unsigned SUM_W   = 18,
   localparam int unsigned NUM_GROUPS = ROW_LEN / GROUP,
   localparam int unsigned GW         = rpe_pkg::idx_bits(NUM_GROUPS),
   localparam int unsigned GRP_SW     = GROUP * SUM_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [GW-1:0]            grp,
   input  logic                     last,
   input  logic [GRP_SW-1:0]        grp_sums,
   output logic [ROW_LEN*SUM_W-1:0] line_data,
   output logic                     line_valid
);

   logic [ROW_LEN*SUM_W-1:0] line_q;
   logic                     valid_q;
   logic [ROW_LEN*SUM_W-1:0] line_next;

   if (NUM_GROUPS > 1) begin : g_staged
      logic [(NUM_GROUPS-1)*GRP_SW-1:0] stage_q;
      for (genvar g = 0; g < NUM_GROUPS - 1; g++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stage_q[g*GRP_SW +: GRP_SW] <= '0;
            end else if (wr_en && (grp == GW'(g))) begin
               stage_q[g*GRP_SW +: GRP_SW] <= grp_sums;
            end
         end
      end
      assign line_next = {grp_sums, stage_q};
   end else begin : g_direct
      assign line_next = grp_sums;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q  <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= last;
         if (last) begin
            line_q <= line_next;
         end
      end
   end

   assign line_data  = line_q;
   assign line_valid = valid_q;

endmodule

// File: rtl/row_prefix_engine.sv
// Row running-sum engine: GROUP pixels per cycle, carry chained across groups.
module row_prefix_engine #(
   parameter int unsigned PIX_W   = 8,
   parameter int unsigned ROW_LEN = 24,
   parameter int unsigned GROUP   = 8,
   parameter int unsigned SUM_W   = 18,
   parameter rpe_pkg::adder_style_e ADDER_STYLE = rpe_pkg::ADD_LOGTREE
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     row_valid,
   input  logic [ROW_LEN*PIX_W-1:0] row_data,
   output logic                     line_valid,
   output logic [ROW_LEN*SUM_W-1:0] line_data
);

   localparam int unsigned NUM_GROUPS = ROW_LEN / GROUP;
   localparam int unsigned GW         = rpe_pkg::idx_bits(NUM_GROUPS);
   localparam int unsigned GRP_PB     = GROUP * PIX_W;
   localparam int unsigned GRP_SW     = GROUP * SUM_W;

   // elaboration-time parameter checks
   if (GROUP == 0 || ROW_LEN % GROUP != 0) begin : g_bad_group
      $error("row length must be a nonzero multiple of the group width");
   end
   if (SUM_W < rpe_pkg::min_sum_bits(ROW_LEN, PIX_W)) begin : g_bad_sum
      $error("sum width too narrow for a full row of maximal pixels");
   end

   logic                     row_accept;
   logic                     busy;
   logic                     last;
   logic [GW-1:0]            grp;
   logic [ROW_LEN*PIX_W-1:0] row_q;
   logic [GRP_PB-1:0]        grp_pix;
   logic [SUM_W-1:0]         carry_q;
   logic [SUM_W-1:0]         carry_in;
   logic [GRP_SW-1:0]        grp_sums;

   rpe_sequencer #(
      .NUM_GROUPS (NUM_GROUPS)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .row_valid (row_valid),
      .accept    (row_accept),
      .busy      (busy),
      .grp       (grp),
      .last      (last)
   );

   // row register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_q <= '0;
      end else if (row_accept) begin
         row_q <= row_data;
      end
   end

   // group select
   always_comb begin
      grp_pix = '0;
      for (int g = 0; g < NUM_GROUPS; g++) begin
         if (grp == GW'(g)) begin
            grp_pix = row_q[g*GRP_PB +: GRP_PB];
         end
      end
   end

   // running total handed from group to group, zero for the first group
   assign carry_in = (grp == '0) ? '0 : carry_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         carry_q <= '0;
      end else if (busy) begin
         carry_q <= grp_sums[GRP_SW-SUM_W +: SUM_W];
      end
   end

   rpe_group_adder #(
      .PIX_W (PIX_W),
      .GROUP (GROUP),
      .SUM_W (SUM_W),
      .STYLE (ADDER_STYLE)
   ) u_add (
      .grp_pix  (grp_pix),
      .carry_in (carry_in),
      .grp_sums (grp_sums)
   );

   rpe_line_buffer #(
      .ROW_LEN (ROW_LEN),
      .GROUP   (GROUP),
      .SUM_W   (SUM_W)
   ) u_buf (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (busy),
      .grp        (grp),
      .last       (last),
      .grp_sums   (grp_sums),
      .line_data  (line_data),
      .line_valid (line_valid)
   );

endmodule

// File: rtl/rpe_checker.sv
// Protocol and arithmetic properties of row_prefix_engine.
module rpe_checker #(
   parameter int unsigned PIX_W   = 8,
   parameter int unsigned ROW_LEN = 24,
   parameter int unsigned GROUP   = 8,
   parameter int unsigned SUM_W   = 18,
   localparam int unsigned NUM_GROUPS = ROW_LEN / GROUP,
   localparam int unsigned CW         = $clog2(NUM_GROUPS + 2),
   localparam int unsigned PIX_MAX    = (1 << PIX_W) - 1
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     accept,
   input logic                     line_valid,
   input logic [ROW_LEN*SUM_W-1:0] line_data
);

   // cycles since the last accepted row, saturating
   logic [CW-1:0] since_acc;
   // cycles since the last line pulse, saturating
   logic [CW-1:0] gap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_acc <= '0;
         gap       <= CW'(NUM_GROUPS);
      end else begin
         if (accept) begin
            since_acc <= CW'(1);
         end else if (since_acc != '0 && since_acc <= CW'(NUM_GROUPS)) begin
            since_acc <= since_acc + CW'(1);
         end
         if (line_valid) begin
            gap <= CW'(1);
         end else if (gap < CW'(NUM_GROUPS)) begin
            gap <= gap + CW'(1);
         end
      end
   end

   // R2: a line appears exactly NUM_GROUPS edges after its accepting edge
   a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
      line_valid |-> ($past(since_acc) == CW'(NUM_GROUPS)));

   // R3: line pulses are never closer than one row time
   a_r3_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      line_valid |-> (gap >= CW'(NUM_GROUPS)));

   // R5: output held between pulses
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !line_valid |-> $stable(line_data));

   // R1 / R6: each step of a published line is one pixel, no wrap
   a_r1_first: assert property (@(posedge clk) disable iff (!rst_n)
      line_valid |-> (line_data[SUM_W-1:0] <= SUM_W'(PIX_MAX)));

   for (genvar i = 1; i < ROW_LEN; i++) begin : g_step
      a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
         line_valid |->
            (line_data[i*SUM_W +: SUM_W] >= line_data[(i-1)*SUM_W +: SUM_W]) &&
            ((line_data[i*SUM_W +: SUM_W] - line_data[(i-1)*SUM_W +: SUM_W])
               <= SUM_W'(PIX_MAX)));
   end

endmodule

bind row_prefix_engine rpe_checker #(
   .PIX_W   (PIX_W),
   .ROW_LEN (ROW_LEN),
   .GROUP   (GROUP),
   .SUM_W   (SUM_W)
) u_rpe_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .accept     (row_accept),
   .line_valid (line_valid),
   .line_data  (line_data)
);

// File: tb/test_row_prefix_engine.sv
`timescale 1ns/1ps
module test_row_prefix_engine;

   localparam int PIX_W   = 8;
   localparam int ROW_LEN = 24;
   localparam int SUM_W   = 18;
   localparam int ROW_W   = ROW_LEN * PIX_W;
   localparam int LINE_W  = ROW_LEN * SUM_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              row_valid = 1'b0;
   logic [ROW_W-1:0]  row_data = '0;
   logic              line_valid;
   logic [LINE_W-1:0] line_data;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   row_prefix_engine i_row_prefix_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .row_valid  (row_valid),
      .row_data   (row_data),
      .line_valid (line_valid),
      .line_data  (line_data)
   );

   function automatic logic [LINE_W-1:0] ref_line(input logic [ROW_W-1:0] r);
      logic [LINE_W-1:0] o;
      int unsigned acc;
      acc = 0;
      o = '0;
      for (int x = 0; x < ROW_LEN; x++) begin
         acc += r[x*PIX_W +: PIX_W];
         o[x*SUM_W +: SUM_W] = acc[SUM_W-1:0];
      end
      return o;
   endfunction

   function automatic logic [ROW_W-1:0] rand_row();
      logic [ROW_W-1:0] r;
      for (int x = 0; x < ROW_LEN; x++) r[x*PIX_W +: PIX_W] = 8'($urandom);
      return r;
   endfunction

   task automatic check(input bit ok, input string tag,
                        input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one row alone; optionally a stray row offered mid-flight (R4)
   task automatic one_row(input logic [ROW_W-1:0] r, input bit intrude, input string tag);
      logic [LINE_W-1:0] exp;
      exp = ref_line(r);
      @(negedge clk);
      row_valid = 1'b1;
      row_data  = r;
      @(negedge clk);                 // n1: accepted at previous edge
      check(line_valid == 1'b0, {tag, " R2 no early pulse n1"}, LINE_W'(line_valid), '0);
      if (intrude) begin
         row_valid = 1'b1;
         row_data  = ~r;
      end else begin
         row_valid = 1'b0;
      end
      @(negedge clk);                 // n2
      row_valid = 1'b0;
      check(line_valid == 1'b0, {tag, " R2 no early pulse n2"}, LINE_W'(line_valid), '0);
      @(negedge clk);                 // n3
      check(line_valid == 1'b0, {tag, " R2 no early pulse n3"}, LINE_W'(line_valid), '0);
      @(negedge clk);                 // n4
      check(line_valid == 1'b1, {tag, " R2 pulse"}, LINE_W'(line_valid), LINE_W'(1));
      check(line_data == exp, {tag, " R1 sums"}, line_data, exp);
      @(negedge clk);                 // n5
      check(line_valid == 1'b0, {tag, " R4 single pulse"}, LINE_W'(line_valid), '0);
      check(line_data == exp, {tag, " R5 hold"}, line_data, exp);
   endtask

   // two rows back to back (R3, R8)
   task automatic pair_rows(input logic [ROW_W-1:0] a, input logic [ROW_W-1:0] b);
      logic [LINE_W-1:0] ea;
      logic [LINE_W-1:0] eb;
      ea = ref_line(a);
      eb = ref_line(b);
      @(negedge clk);
      row_valid = 1'b1;
      row_data  = a;
      @(negedge clk);                 // n1
      row_valid = 1'b0;
      @(negedge clk);                 // n2
      @(negedge clk);                 // n3: offer b for the completing edge
      row_valid = 1'b1;
      row_data  = b;
      @(negedge clk);                 // n4
      row_valid = 1'b0;
      check(line_valid == 1'b1 && line_data == ea, "R3 first line", line_data, ea);
      @(negedge clk);                 // n5
      check(line_valid == 1'b0, "R3 gap n5", LINE_W'(line_valid), '0);
      @(negedge clk);                 // n6
      check(line_valid == 1'b0, "R3 gap n6", LINE_W'(line_valid), '0);
      @(negedge clk);                 // n7
      check(line_valid == 1'b1, "R3 second pulse three cycles later",
            LINE_W'(line_valid), LINE_W'(1));
      check(line_data == eb, "R8 second row starts from zero", line_data, eb);
      @(negedge clk);
   endtask

   initial begin
      logic [ROW_W-1:0] r;
      logic [LINE_W-1:0] exp;
      void'($urandom(32'd2024));
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(line_valid == 1'b0, "R7 reset valid", LINE_W'(line_valid), '0);
      check(line_data == '0, "R7 reset data", line_data, '0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(line_valid == 1'b0 && line_data == '0, "R7 idle after reset", line_data, '0);

      // all zero
      one_row('0, 1'b0, "zero row");

      // all 255: maximum sums
      r = '1;
      one_row(r, 1'b0, "R6 full row");
      exp = '0;
      exp[SUM_W-1:0] = 18'd6120;
      check(line_data[(ROW_LEN-1)*SUM_W +: SUM_W] == 18'd6120, "R6 last entry 6120",
            LINE_W'(line_data[(ROW_LEN-1)*SUM_W +: SUM_W]), exp);

      // ascending pixels: checks index ordering
      for (int x = 0; x < ROW_LEN; x++) r[x*PIX_W +: PIX_W] = 8'(x + 1);
      one_row(r, 1'b0, "R1 ascending");

      // single pixel at the rightmost position
      r = '0;
      r[(ROW_LEN-1)*PIX_W +: PIX_W] = 8'd200;
      one_row(r, 1'b0, "R1 rightmost only");

      // single pixel at the leftmost position
      r = '0;
      r[PIX_W-1:0] = 8'd1;
      one_row(r, 1'b1, "R1 leftmost only");

      // random rows, half with an ignored intruding row
      for (int n = 0; n < 12; n++) begin
         one_row(rand_row(), n[0], "random");
      end

      // back-to-back pairs, including max followed by small
      pair_rows('1, rand_row());
      for (int n = 0; n < 3; n++) pair_rows(rand_row(), rand_row());

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule